// File: doc/BRIEF.md
# Batched-Interrupt Sample Buffer with Adaptive Threshold

This block is a synchronous first-in first-out buffer for a stream of samples. It sits between a sampling front end and a reader, such as a DMA engine or a host. Samples enter on a valid/ready write port and leave through a show-ahead read port. Instead of signalling the reader for every word, the block raises one level-sensitive interrupt request once the buffered amount reaches a threshold. The reader can then drain a whole batch for each request.

The threshold has two sources. In static mode it comes from a configuration input, and a value of zero selects half the depth. In adaptive mode it comes from an exponentially decaying average of the cycle gaps between accepted samples. The decay shift is programmable. Dense arrivals raise the threshold, so batches are larger. Sparse arrivals lower it, so a slow trickle still reaches the reader with bounded delay. The result is clamped between one eighth and seven eighths of the depth.

The buffer depth is twice the configured worst-case burst length. A sample offered while the buffer is full is refused and never overwrites stored data. Each refused sample sets a sticky overflow flag and increments a saturating drop counter. The fill level and the active threshold are outputs of the block.

Top module: `batch_irq_fifo`

## Requirements
- R1: After reset, fill_level is 0, rd_valid is 0, wr_ready is 1, irq is 0, ovf_flag is 0 and drop_count is 0.
- R2: Samples leave in the order they were accepted. rd_data shows the oldest entry whenever rd_valid is 1. A cycle with rd_en high and rd_valid high removes that entry. Each clock edge changes fill_level by at most one step.
- R3: In static mode (cfg_adaptive = 0), active_thr equals cfg_thr. If cfg_thr is 0, active_thr is DEPTH/2. If cfg_thr is above DEPTH, active_thr is DEPTH.
- R4: irq is high exactly while fill_level ≥ active_thr and the current batch has not been acknowledged. An irq_ack pulse while irq is high drops irq from the next cycle. irq stays low until fill_level has been below active_thr at a clock edge, which re-arms it for the next batch.
- R5: irq is combinational from the fill level and the threshold. It falls in the same cycle in which a read takes fill_level below active_thr.
- R6: DEPTH is 2·BURST_LEN. With fill_level = DEPTH, wr_ready is 0. A sample offered then is refused, and the stored contents and their order stay unchanged.
- R7: Each refused sample sets ovf_flag, which stays set until an ovf_clr pulse. If ovf_clr and a refused sample fall in the same cycle, the flag ends up set.
- R8: drop_count counts refused samples and saturates at 2^DROP_W − 1 (65535 by default). An ovf_clr pulse clears it to 0, or to 1 if a sample is refused in that same cycle.
- R9: A gap counter is loaded with 1 at reset and at every accepted write. It increments on every other edge and saturates at 2^GAP_W − 1. Its value at an accepted write is that write's interval, so back-to-back writes give 1.
- R10: On each accepted write, the average updates as avg ← avg + ((interval − avg) >>> cfg_decay), using an arithmetic shift. With cfg_decay = 0 the average equals the interval. The average is 0 after reset.
- R11: In adaptive mode (cfg_adaptive = 1), active_thr = HI − (avg >> GAP_SHIFT), limited to the range [LO, HI]. LO is DEPTH/8 and HI is 7·DEPTH/8 (2 and 14 by default).
- R12: cfg_adaptive selects the threshold source combinationally. A change of mode changes active_thr and irq without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Sample offered |
| wr_data | input | DATA_W | Offered sample |
| wr_ready | output | 1 | Buffer can accept a sample |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | DATA_W | Head entry (show-ahead) |
| rd_valid | output | 1 | Buffer is not empty |
| fill_level | output | CNT_W | Number of stored entries |
| cfg_adaptive | input | 1 | 1 = adaptive threshold, 0 = static threshold |
| cfg_thr | input | CNT_W | Static threshold, 0 = DEPTH/2 |
| cfg_decay | input | 3 | Shift applied to the average update |
| irq_ack | input | 1 | Acknowledge the current batch |
| ovf_clr | input | 1 | Clear the overflow flag and the drop counter |
| irq | output | 1 | Level-sensitive batch interrupt request |
| active_thr | output | CNT_W | Threshold currently in force |
| ovf_flag | output | 1 | Sticky overflow indication |
| drop_count | output | DROP_W | Saturating count of refused samples |

## Verification
The bench drives the gap counter past its limit with an idle stretch chosen so that a wrapping counter would give an interval of 1 and a threshold of 14 rather than 2. It applies a negative average step at shift 7, where a logical shift instead of an arithmetic one would make the average jump far away instead of moving down by one. It acknowledges a batch and then adds a sample above threshold, which a design that re-raises on every word would flag. It clears overflow in the same cycle as a refused sample, and it holds the buffer full for more than 65535 cycles so that a counter that wraps would read a small value. It also reads a full buffer back after a refused sample to catch a design that overwrites an entry.

// File: rtl/batch_irq_pkg.sv
package batch_irq_pkg;

    typedef enum logic {
        THR_STATIC   = 1'b0,
        THR_ADAPTIVE = 1'b1
    } thr_mode_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic drop;
    } fifo_evt_t;

    // n/8 of depth, never below one entry
    function automatic int unsigned eighths_of(input int unsigned depth, input int unsigned n);
        int unsigned v;
        v = (depth * n) / 8;
        if (v == 0) v = 1;
        return v;
    endfunction

endpackage

// File: rtl/bif_store.sv
module bif_store
    import batch_irq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 16,
    parameter int PTR_W  = 4,
    parameter int CNT_W  = 5
)(
    input  logic              clk,
    input  logic              rst,
    input  fifo_evt_t         evt,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic [CNT_W-1:0]  count
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;

    generate
        if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
            always_comb begin
                wr_nxt = wr_ptr + PTR_W'(1);
                rd_nxt = rd_ptr + PTR_W'(1);
            end
        end else begin : g_mod
            always_comb begin
                wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
                rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (evt.push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (evt.push) wr_ptr <= wr_nxt;
            if (evt.pop)  rd_ptr <= rd_nxt;
            count <= count + CNT_W'(evt.push) - CNT_W'(evt.pop);
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/bif_gap_avg.sv
module bif_gap_avg #(
    parameter int GAP_W = 12
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [2:0]       decay,
    output logic [GAP_W-1:0] avg
);
    logic [GAP_W-1:0]        gap_q;
    logic signed [GAP_W:0]   diff, step, sum;

    // cycles since the previous accepted write, saturating
    always_ff @(posedge clk) begin
        if (rst)                  gap_q <= GAP_W'(1);
        else if (accept)          gap_q <= GAP_W'(1);
        else if (gap_q != '1)     gap_q <= gap_q + GAP_W'(1);
    end

    always_comb begin
        diff = $signed({1'b0, gap_q}) - $signed({1'b0, avg});
        step = diff >>> decay;
        sum  = $signed({1'b0, avg}) + step;
    end

    always_ff @(posedge clk) begin
        if (rst)         avg <= '0;
        else if (accept) avg <= sum[GAP_W-1:0];
    end

endmodule

// File: rtl/bif_thr_sel.sv
module bif_thr_sel
    import batch_irq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CNT_W     = 5,
    parameter int GAP_W     = 12,
    parameter int GAP_SHIFT = 2,
    parameter int THR_LO    = 2,
    parameter int THR_HI    = 14
)(
    input  thr_mode_e        mode,
    input  logic [CNT_W-1:0] static_thr,
    input  logic [GAP_W-1:0] avg,
    output logic [CNT_W-1:0] thr
);
    localparam int SPAN = THR_HI - THR_LO;

    logic [CNT_W-1:0] static_val, adapt_val;
    logic [GAP_W-1:0] scaled;

    always_comb begin
        if (static_thr == '0)                 static_val = CNT_W'(DEPTH / 2);
        else if (static_thr > CNT_W'(DEPTH))  static_val = CNT_W'(DEPTH);
        else                                  static_val = static_thr;
    end

    // longer gaps pull the threshold down toward LO
    always_comb begin
        scaled = avg >> GAP_SHIFT;
        if (scaled >= GAP_W'(SPAN)) adapt_val = CNT_W'(THR_LO);
        else                        adapt_val = CNT_W'(THR_HI) - CNT_W'(scaled);
    end

    assign thr = (mode == THR_ADAPTIVE) ? adapt_val : static_val;

endmodule

// File: rtl/bif_event_ctrl.sv
module bif_event_ctrl #(
    parameter int CNT_W  = 5,
    parameter int DROP_W = 16
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  fill,
    input  logic [CNT_W-1:0]  thr,
    input  logic              ack,
    input  logic              drop,
    input  logic              clr,
    output logic              irq,
    output logic              ovf,
    output logic [DROP_W-1:0] drops
);
    logic above, served_q;

    assign above = (fill >= thr);

    // one request per batch: an acknowledge holds it off until fill dips
    always_ff @(posedge clk) begin
        if (rst)         served_q <= 1'b0;
        else if (!above) served_q <= 1'b0;
        else if (ack)    served_q <= 1'b1;
    end

    assign irq = above && !served_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf   <= 1'b0;
            drops <= '0;
        end else if (clr) begin
            ovf   <= drop;
            drops <= DROP_W'(drop);
        end else if (drop) begin
            ovf <= 1'b1;
            if (drops != '1) drops <= drops + DROP_W'(1);
        end
    end

endmodule

// File: rtl/batch_irq_fifo.sv
module batch_irq_fifo
    import batch_irq_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int BURST_LEN = 8,
    parameter int GAP_W     = 12,
    parameter int GAP_SHIFT = 2,
    parameter int DROP_W    = 16,
    localparam int DEPTH    = 2 * BURST_LEN,
    localparam int CNT_W    = $clog2(DEPTH + 1)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ready,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  fill_level,
    input  logic              cfg_adaptive,
    input  logic [CNT_W-1:0]  cfg_thr,
    input  logic [2:0]        cfg_decay,
    input  logic              irq_ack,
    input  logic              ovf_clr,
    output logic              irq,
    output logic [CNT_W-1:0]  active_thr,
    output logic              ovf_flag,
    output logic [DROP_W-1:0] drop_count
);
    localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int THR_LO = int'(eighths_of(DEPTH, 1));
    localparam int THR_HI = int'(eighths_of(DEPTH, 7));

    fifo_evt_t        evt;
    logic             full, empty;
    logic [CNT_W-1:0] fill;
    logic [GAP_W-1:0] avg;
    thr_mode_e        mode;

    always_comb begin
        full     = (fill == CNT_W'(DEPTH));
        empty    = (fill == '0);
        evt.push = wr_valid && !full;
        evt.pop  = rd_en && !empty;
        evt.drop = wr_valid && full;
    end

    assign mode       = thr_mode_e'(cfg_adaptive);
    assign wr_ready   = !full;
    assign rd_valid   = !empty;
    assign fill_level = fill;

    bif_store #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst(rst), .evt(evt), .din(wr_data),
        .dout(rd_data), .count(fill)
    );

    bif_gap_avg #(
        .GAP_W(GAP_W)
    ) u_gap (
        .clk(clk), .rst(rst), .accept(evt.push), .decay(cfg_decay), .avg(avg)
    );

    bif_thr_sel #(
        .DEPTH(DEPTH), .CNT_W(CNT_W), .GAP_W(GAP_W), .GAP_SHIFT(GAP_SHIFT),
        .THR_LO(THR_LO), .THR_HI(THR_HI)
    ) u_thr (
        .mode(mode), .static_thr(cfg_thr), .avg(avg), .thr(active_thr)
    );

    bif_event_ctrl #(
        .CNT_W(CNT_W), .DROP_W(DROP_W)
    ) u_evt (
        .clk(clk), .rst(rst), .fill(fill), .thr(active_thr), .ack(irq_ack),
        .drop(evt.drop), .clr(ovf_clr), .irq(irq), .ovf(ovf_flag),
        .drops(drop_count)
    );

endmodule

// File: rtl/batch_irq_fifo_chk.sv
module batch_irq_fifo_chk #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5,
    parameter int DROP_W = 16
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [CNT_W-1:0]  fill_level,
    input logic              cfg_adaptive,
    input logic              irq_ack,
    input logic              ovf_clr,
    input logic              irq,
    input logic [CNT_W-1:0]  active_thr,
    input logic              ovf_flag,
    input logic [DROP_W-1:0] drop_count
);
    localparam int LO = ((DEPTH / 8) == 0) ? 1 : DEPTH / 8;
    localparam int HI = ((DEPTH * 7 / 8) == 0) ? 1 : DEPTH * 7 / 8;

    assert_fill_bound_R6: assert property (@(posedge clk) disable iff (rst)
        fill_level <= CNT_W'(DEPTH));

    assert_full_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (fill_level == CNT_W'(DEPTH)) |-> !wr_ready);

    assert_fill_step_R2: assert property (@(posedge clk) disable iff (rst)
        (fill_level == $past(fill_level)) ||
        (fill_level == $past(fill_level) + CNT_W'(1)) ||
        (fill_level == $past(fill_level) - CNT_W'(1)));

    assert_refuse_flags_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> ovf_flag);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (rst)
        (ovf_clr && !(wr_valid && !wr_ready)) |=> !ovf_flag);

    assert_drop_sat_R8: assert property (@(posedge clk) disable iff (rst)
        (drop_count == '1 && !ovf_clr) |=> (drop_count == '1));

    assert_irq_level_R4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (fill_level >= active_thr));

    assert_ack_quiets_R4: assert property (@(posedge clk) disable iff (rst)
        (irq && irq_ack) |=> !irq);

    assert_thr_window_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_adaptive |-> (active_thr >= CNT_W'(LO) && active_thr <= CNT_W'(HI)));

endmodule

bind batch_irq_fifo batch_irq_fifo_chk #(
    .DEPTH(DEPTH), .CNT_W(CNT_W), .DROP_W(DROP_W)
) u_chk (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .fill_level(fill_level), .cfg_adaptive(cfg_adaptive), .irq_ack(irq_ack),
    .ovf_clr(ovf_clr), .irq(irq), .active_thr(active_thr),
    .ovf_flag(ovf_flag), .drop_count(drop_count)
);

// File: tb/sim_batch_irq_fifo.sv
module sim_batch_irq_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int CW = 5;
    localparam int DEP = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_valid, rd_en, irq_ack, ovf_clr, cfg_adaptive;
    logic [DW-1:0] wr_data;
    logic [CW-1:0] cfg_thr;
    logic [2:0]    cfg_decay;
    logic          wr_ready, rd_valid, irq, ovf_flag;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] fill_level, active_thr;
    logic [15:0]   drop_count;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    batch_irq_fifo u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
        .fill_level(fill_level), .cfg_adaptive(cfg_adaptive), .cfg_thr(cfg_thr),
        .cfg_decay(cfg_decay), .irq_ack(irq_ack), .ovf_clr(ovf_clr), .irq(irq),
        .active_thr(active_thr), .ovf_flag(ovf_flag), .drop_count(drop_count)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // one clock: inputs held across a single rising edge, then released
    task automatic cyc(input logic wv, input logic [DW-1:0] wd, input logic re,
                       input logic ack, input logic clr);
        wr_valid = wv; wr_data = wd; rd_en = re; irq_ack = ack; ovf_clr = clr;
        @(negedge clk);
        wr_valid = 1'b0; rd_en = 1'b0; irq_ack = 1'b0; ovf_clr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic do_reset();
        rst = 1'b1; cfg_adaptive = 1'b0; cfg_thr = '0; cfg_decay = '0;
        wr_valid = 1'b0; wr_data = '0; rd_en = 1'b0; irq_ack = 1'b0; ovf_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 fill", int'(fill_level), 0);
        check("R1 rd_valid", int'(rd_valid), 0);
        check("R1 wr_ready", int'(wr_ready), 1);
        check("R1 irq", int'(irq), 0);
        check("R1 ovf", int'(ovf_flag), 0);
        check("R1 drops", int'(drop_count), 0);
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 5; i++) cyc(1'b1, DW'(16'h100 + i), 1'b0, 1'b0, 1'b0);
        check("R2 fill after 5", int'(fill_level), 5);
        for (int i = 0; i < 5; i++) begin
            check("R2 head data", int'(rd_data), 16'h100 + i);
            cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        end
        check("R2 empty", int'(rd_valid), 0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check("R2 read when empty", int'(fill_level), 0);
    endtask

    task automatic t_static_thr();
        do_reset();
        check("R3 default half", int'(active_thr), DEP / 2);
        cfg_thr = 5'd5;
        #1 check("R3 programmed", int'(active_thr), 5);
        cfg_thr = 5'd20;
        #1 check("R3 clamp to depth", int'(active_thr), DEP);
        cfg_thr = '0;
    endtask

    task automatic t_irq_batch();
        do_reset();
        for (int i = 0; i < 7; i++) cyc(1'b1, DW'(i), 1'b0, 1'b0, 1'b0);
        check("R4 below thr", int'(irq), 0);
        cyc(1'b1, DW'(7), 1'b0, 1'b0, 1'b0);
        check("R4 at thr", int'(irq), 1);
        cyc(1'b0, '0, 1'b0, 1'b1, 1'b0);
        check("R4 ack drops irq", int'(irq), 0);
        cyc(1'b1, DW'(8), 1'b0, 1'b0, 1'b0);
        check("R4 once per batch", int'(irq), 0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check("R4 fill 7", int'(fill_level), 7);
        cyc(1'b1, DW'(9), 1'b0, 1'b0, 1'b0);
        check("R4 rearmed", int'(irq), 1);
        cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        check("R5 read clears irq", int'(irq), 0);
    endtask

    task automatic t_overflow();
        do_reset();
        cfg_thr = 5'd16;
        for (int i = 0; i < DEP; i++) cyc(1'b1, DW'(16'h200 + i), 1'b0, 1'b0, 1'b0);
        check("R6 ready low when full", int'(wr_ready), 0);
        check("R6 irq at full thr", int'(irq), 1);
        check("R7 no ovf yet", int'(ovf_flag), 0);
        cyc(1'b1, 16'hDEAD, 1'b0, 1'b0, 1'b0);
        check("R6 fill held", int'(fill_level), DEP);
        check("R7 ovf set", int'(ovf_flag), 1);
        check("R8 one drop", int'(drop_count), 1);
        for (int i = 0; i < DEP; i++) begin
            check("R6 contents intact", int'(rd_data), 16'h200 + i);
            cyc(1'b0, '0, 1'b1, 1'b0, 1'b0);
        end
        check("R7 sticky", int'(ovf_flag), 1);
        cyc(1'b0, '0, 1'b0, 1'b0, 1'b1);
        check("R7 cleared", int'(ovf_flag), 0);
        check("R8 cleared", int'(drop_count), 0);
        cfg_thr = '0;
    endtask

    task automatic t_drop_sat();
        do_reset();
        for (int i = 0; i < DEP; i++) cyc(1'b1, DW'(i), 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 16'h0BAD, 1'b0, 1'b0, 1'b1);
        check("R7 drop beats clear", int'(ovf_flag), 1);
        check("R8 clear with drop", int'(drop_count), 1);
        wr_valid = 1'b1;
        repeat (65540) @(negedge clk);
        wr_valid = 1'b0;
        check("R8 saturated", int'(drop_count), 65535);
        cyc(1'b1, 16'h0BAD, 1'b0, 1'b0, 1'b0);
        check("R8 stays saturated", int'(drop_count), 65535);
    endtask

    task automatic t_adaptive();
        do_reset();
        cfg_adaptive = 1'b1;
        #1 check("R11 reset avg gives HI", int'(active_thr), 14);
        cyc(1'b1, 16'h1, 1'b0, 1'b0, 1'b0);
        cyc(1'b1, 16'h2, 1'b0, 1'b0, 1'b0);       // interval 1 -> avg 1
        check("R9 back to back", int'(active_thr), 14);
        idle(39);
        cyc(1'b1, 16'h3, 1'b0, 1'b0, 1'b0);       // interval 40 -> avg 40
        check("R10 decay 0 tracks", int'(active_thr), 4);
        cfg_decay = 3'd2;
        idle(7);
        cyc(1'b1, 16'h4, 1'b0, 1'b0, 1'b0);       // interval 8 -> avg 32
        check("R10 decay 2", int'(active_thr), 6);
        cfg_decay = 3'd7;
        cyc(1'b1, 16'h5, 1'b0, 1'b0, 1'b0);       // interval 1 -> avg 31
        check("R10 arithmetic shift", int'(active_thr), 7);
        check("R11 fill below thr", int'(irq), 0);
        cfg_decay = 3'd0;
        idle(4096);
        cyc(1'b1, 16'h6, 1'b0, 1'b0, 1'b0);       // saturates at 4095
        check("R9 saturating gap", int'(active_thr), 2);
        check("R11 sparse irq", int'(irq), 1);
        cfg_adaptive = 1'b0;
        #1 check("R12 switch to static", int'(active_thr), 8);
        check("R12 irq follows", int'(irq), 0);
    endtask

    initial begin
        t_reset();
        t_order();
        t_static_thr();
        t_irq_batch();
        t_overflow();
        t_drop_sat();
        t_adaptive();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule